// File: doc/BRIEF.md
# Display Control Word Decoder

This block takes 32-bit display control words. The top byte of each word picks a command and the low 24 bits carry its arguments. A bank of control slots keeps the last value written to each low-numbered command. A command whose value matches its stored slot is dropped without any effect. The block keeps a 32-bit status word. From the accepted commands it derives the display start position, the horizontal and vertical resolution, the blanking flag, the DMA direction, and the visible width and height.

The visible width is the horizontal range scaled by the resolution over a 2560-unit span. The block computes it in two clock cycles by shift and reciprocal multiply, so it needs no divider. While that recompute runs the block holds `wr_ready_o` low. Information queries read a separate bank of latched drawing-environment words and return the result on `rd_data_o`. Bit 31 of the status output shows an external line-field flag.

Top module: `disp_ctrl_dec`

## Requirements
- R1: After `rst_ni` or an accepted command 0x00 the outputs read as follows: `status_o[30:0]` = 0x14802000, `rd_data_o` = 0, `hres_o` = `width_o` = 256, `vres_o` = `height_o` = 240. All control slots are cleared except slot 3, which holds 1.
- R2: A write with a nonzero command below 16 whose data equals that command's stored slot value is dropped: no output changes and no busy period. Command 0x00 is never dropped.
- R3: Command 0x03 copies data bit 0 to `blank_o` (status bit 23). Command 0x04 copies data bits 1:0 to `dma_dir_o` (status bits 30:29).
- R4: Command 0x05 sets `disp_x_o` from data bits 9:0 and `disp_y_o` from bits 19:10.
- R5: Command 0x06 sets x1 from bits 11:0 and x2 from bits 23:12. Let d = x2−x1. If d ≤ 0 or d ≥ 2560 then `width_o` = `hres_o`. Otherwise `width_o` = floor(d·hres/2560).
- R6: Command 0x07 sets y1 from bits 9:0 and y2 from bits 19:10. `height_o` = y2−y1, doubled when status bit 19 is set. A result ≤ 0 gives `vres_o` instead.
- R7: Command 0x08 puts data bits 5:0 into status bits 22:17 and data bit 6 into status bit 16. `hres_o` = {256,368,320,384,512,512,640,640}[status 18:16] and `vres_o` = {240,480,256,480}[status 20:19]. Width and height are then both recomputed.
- R8: Commands 0x10–0x1F set `rd_data_o` from their low nibble n. For n of 2 to 5 the result is the low 20 bits of environment word n. For n = 6 it is the low 20 bits of word 5. For n = 7 it is 2. Any other n gives 0. Environment words are written through `env_we_i`/`env_idx_i`/`env_data_i`.
- R9: `status_o[31]` always equals `lcf_i`.
- R10: An accepted, non-dropped command 0x06, 0x07 or 0x08 drives `wr_ready_o` low for exactly two cycles. When it returns high, width and height hold their new values. A word presented while `wr_ready_o` is low is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Control word valid |
| wr_data_i | input | 32 | Control word: command in 31:24 |
| wr_ready_o | output | 1 | Word accepted on this edge when high with valid |
| env_we_i | input | 1 | Environment word write enable |
| env_idx_i | input | 3 | Environment word index |
| env_data_i | input | 32 | Environment word value |
| lcf_i | input | 1 | External line-field flag |
| status_o | output | 32 | Status word, bit 31 = lcf_i |
| rd_data_o | output | 32 | Query result |
| busy_o | output | 1 | Width/height recompute in progress |
| disp_x_o | output | 10 | Display start x |
| disp_y_o | output | 10 | Display start y |
| hres_o | output | 10 | Horizontal resolution |
| vres_o | output | 9 | Vertical resolution |
| width_o | output | 10 | Visible width |
| height_o | output | 11 | Visible height |
| blank_o | output | 1 | Blanking flag |
| dma_dir_o | output | 2 | DMA direction |

## Verification
The range commands are driven with random 12-bit and 10-bit endpoints. These cover negative, zero, in-range and oversized spans, so they separate the fallback path from the scaled-width path. Directed spans of 2559 and 2560 pin down the edge of the scale window and the rounding of the reciprocal multiply. The mode command walks resolution indices with double height both on and off, which shows whether width and height follow the new tables. Repeated slot values, a repeated reset, and a word held during the busy window separate the dropped path, the never-dropped path and the stalled path from ordinary writes.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int CMD_W       = 8;
  localparam int HRES_W      = 10;
  localparam int VRES_W      = 9;
  localparam int WID_W       = 10;
  localparam int HGT_W       = 11;
  localparam int XR_W        = 12;
  localparam int YR_W        = 10;
  localparam int BLANK_BIT   = 23;
  localparam int DHEIGHT_BIT = 19;
  localparam int DMA_LSB     = 29;
  localparam int RANGE_FULL  = 2560;
  // 2560 = 512 * 5; divide by 5 via 3277/2^14, exact for quotients < 16384
  localparam int PRE_SHIFT   = 9;
  localparam int RECIP_MUL   = 3277;
  localparam int RECIP_SHIFT = 14;
  localparam logic [31:0]       STATUS_RST = 32'h1480_2000;
  localparam logic [HRES_W-1:0] HRES_RST   = 10'd256;
  localparam logic [VRES_W-1:0] VRES_RST   = 9'd240;

  typedef enum logic [CMD_W-1:0] {
    CMD_RESET  = 8'h00,
    CMD_BLANK  = 8'h03,
    CMD_DMA    = 8'h04,
    CMD_START  = 8'h05,
    CMD_HRANGE = 8'h06,
    CMD_VRANGE = 8'h07,
    CMD_MODE   = 8'h08
  } cmd_e;

  function automatic logic [HRES_W-1:0] hres_of(input logic [2:0] i);
    case (i)
      3'd0:    return 10'd256;
      3'd1:    return 10'd368;
      3'd2:    return 10'd320;
      3'd3:    return 10'd384;
      3'd4,
      3'd5:    return 10'd512;
      default: return 10'd640;
    endcase
  endfunction

  function automatic logic [VRES_W-1:0] vres_of(input logic [1:0] i);
    case (i)
      2'd0:    return 9'd240;
      2'd2:    return 9'd256;
      default: return 9'd480;
    endcase
  endfunction
endpackage

// File: rtl/disp_ctrl_bank.sv
module disp_ctrl_bank #(
  parameter int SLOTS = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [7:0]  cmd_i,
  input  logic [31:0] data_i,
  output logic        drop_o
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [31:0]      slot_q [SLOTS];
  logic             in_range;
  logic [IDX_W-1:0] idx;

  generate
    if (SLOTS >= 256) begin : g_all
      assign in_range = 1'b1;
    end else begin : g_lim
      assign in_range = ({24'd0, cmd_i} < 32'(SLOTS));
    end
  endgenerate

  assign idx    = IDX_W'(cmd_i);
  assign drop_o = (cmd_i != 8'h00) && in_range && (slot_q[idx] == data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SLOTS; s++) slot_q[s] <= (s == 3) ? 32'd1 : 32'd0;
    end else if (wr_i && !drop_o) begin
      if (cmd_i == 8'h00) begin
        for (int s = 0; s < SLOTS; s++) slot_q[s] <= (s == 3) ? 32'd1 : 32'd0;
      end else if (in_range) begin
        slot_q[idx] <= data_i;
      end
    end
  end
endmodule

// File: rtl/disp_env_query.sv
module disp_env_query #(
  parameter int ENV_WORDS = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [2:0]  idx_i,
  input  logic [31:0] data_i,
  input  logic [3:0]  sel_i,
  output logic [31:0] val_o
);
  localparam int EIDX_W = $clog2(ENV_WORDS);

  logic [31:0] env_q [ENV_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENV_WORDS; e++) env_q[e] <= '0;
    end else if (we_i) begin
      env_q[EIDX_W'(idx_i)] <= data_i;
    end
  end

  always_comb begin
    case (sel_i)
      4'd2, 4'd3, 4'd4, 4'd5: val_o = {12'd0, env_q[EIDX_W'(sel_i[2:0])][19:0]};
      4'd6:                   val_o = {12'd0, env_q[EIDX_W'(5)][19:0]};
      4'd7:                   val_o = 32'd2;
      default:                val_o = 32'd0;
    endcase
  end
endmodule

// File: rtl/disp_scale.sv
module disp_scale
  import disp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              force_i,
  input  logic              start_i,
  input  logic              upd_w_i,
  input  logic              upd_h_i,
  input  logic [XR_W-1:0]   x1_i,
  input  logic [XR_W-1:0]   x2_i,
  input  logic [YR_W-1:0]   y1_i,
  input  logic [YR_W-1:0]   y2_i,
  input  logic [HRES_W-1:0] hres_i,
  input  logic [VRES_W-1:0] vres_i,
  input  logic              dheight_i,
  output logic [WID_W-1:0]  width_o,
  output logic [HGT_W-1:0]  height_o,
  output logic              busy_o
);
  localparam int PROD_W = XR_W + HRES_W;
  localparam int QDIV_W = PROD_W - PRE_SHIFT;
  localparam int QMUL_W = QDIV_W + 13;

  logic [1:0]        cnt_q;
  logic              upd_w_q, upd_h_q, full_q;
  logic [PROD_W-1:0] prod_q;
  logic [WID_W-1:0]  width_q;
  logic [HGT_W-1:0]  height_q;

  logic signed [XR_W:0]   dx;
  logic signed [YR_W+1:0] dy, dy2;
  logic [QDIV_W-1:0]      qdiv;
  logic [QMUL_W-1:0]      qmul;
  logic [WID_W-1:0]       w_scaled;
  logic [HGT_W-1:0]       h_new;

  assign dx       = $signed({1'b0, x2_i}) - $signed({1'b0, x1_i});
  assign dy       = $signed({2'b00, y2_i}) - $signed({2'b00, y1_i});
  assign dy2      = dheight_i ? (dy <<< 1) : dy;
  assign h_new    = (dy2 <= 0) ? HGT_W'(vres_i) : dy2[HGT_W-1:0];
  assign qdiv     = prod_q[PROD_W-1:PRE_SHIFT];
  assign qmul     = QMUL_W'(qdiv) * QMUL_W'(RECIP_MUL);
  assign w_scaled = qmul[RECIP_SHIFT +: WID_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= 2'd0;
      upd_w_q  <= 1'b0;
      upd_h_q  <= 1'b0;
      full_q   <= 1'b0;
      prod_q   <= '0;
      width_q  <= WID_W'(HRES_RST);
      height_q <= HGT_W'(VRES_RST);
    end else if (force_i) begin
      cnt_q    <= 2'd0;
      width_q  <= WID_W'(HRES_RST);
      height_q <= HGT_W'(VRES_RST);
    end else if (start_i) begin
      cnt_q   <= 2'd2;
      upd_w_q <= upd_w_i;
      upd_h_q <= upd_h_i;
    end else if (cnt_q == 2'd2) begin
      prod_q <= PROD_W'(dx[XR_W-1:0]) * PROD_W'(hres_i);
      full_q <= (dx <= 0) || (dx >= (XR_W+1)'(RANGE_FULL));
      cnt_q  <= 2'd1;
    end else if (cnt_q == 2'd1) begin
      if (upd_w_q) width_q <= full_q ? WID_W'(hres_i) : w_scaled;
      if (upd_h_q) height_q <= h_new;
      cnt_q <= 2'd0;
    end
  end

  assign width_o  = width_q;
  assign height_o = height_q;
  assign busy_o   = (cnt_q != 2'd0);
endmodule

// File: rtl/disp_ctrl_dec.sv
module disp_ctrl_dec
  import disp_pkg::*;
#(
  parameter int CTRL_SLOTS = 16,
  parameter int ENV_WORDS  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [31:0]       wr_data_i,
  output logic              wr_ready_o,
  input  logic              env_we_i,
  input  logic [2:0]        env_idx_i,
  input  logic [31:0]       env_data_i,
  input  logic              lcf_i,
  output logic [31:0]       status_o,
  output logic [31:0]       rd_data_o,
  output logic              busy_o,
  output logic [9:0]        disp_x_o,
  output logic [9:0]        disp_y_o,
  output logic [HRES_W-1:0] hres_o,
  output logic [VRES_W-1:0] vres_o,
  output logic [WID_W-1:0]  width_o,
  output logic [HGT_W-1:0]  height_o,
  output logic              blank_o,
  output logic [1:0]        dma_dir_o
);
  logic              accept, drop, act, busy;
  logic [CMD_W-1:0]  cmd;
  logic [31:0]       qval;
  logic [31:0]       status_q, rd_q;
  logic [9:0]        dx_q, dy_q;
  logic [XR_W-1:0]   x1_q, x2_q;
  logic [YR_W-1:0]   y1_q, y2_q;
  logic [HRES_W-1:0] hres_q;
  logic [VRES_W-1:0] vres_q;
  logic              sc_start, sc_force;

  assign cmd        = wr_data_i[31:24];
  assign wr_ready_o = !busy;
  assign accept     = wr_valid_i && wr_ready_o;
  assign act        = accept && !drop;
  assign sc_force   = act && (cmd == CMD_RESET);
  assign sc_start   = act && (cmd == CMD_HRANGE || cmd == CMD_VRANGE || cmd == CMD_MODE);

  disp_ctrl_bank #(.SLOTS(CTRL_SLOTS)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (accept),
    .cmd_i  (cmd),
    .data_i (wr_data_i),
    .drop_o (drop)
  );

  disp_env_query #(.ENV_WORDS(ENV_WORDS)) u_env (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (env_we_i),
    .idx_i  (env_idx_i),
    .data_i (env_data_i),
    .sel_i  (wr_data_i[27:24]),
    .val_o  (qval)
  );

  disp_scale u_scale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .force_i   (sc_force),
    .start_i   (sc_start),
    .upd_w_i   (cmd == CMD_HRANGE || cmd == CMD_MODE),
    .upd_h_i   (cmd == CMD_VRANGE || cmd == CMD_MODE),
    .x1_i      (x1_q),
    .x2_i      (x2_q),
    .y1_i      (y1_q),
    .y2_i      (y2_q),
    .hres_i    (hres_q),
    .vres_i    (vres_q),
    .dheight_i (status_q[DHEIGHT_BIT]),
    .width_o   (width_o),
    .height_o  (height_o),
    .busy_o    (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= STATUS_RST;
      rd_q     <= '0;
      hres_q   <= HRES_RST;
      vres_q   <= VRES_RST;
      dx_q     <= '0;
      dy_q     <= '0;
      x1_q     <= '0;
      x2_q     <= '0;
      y1_q     <= '0;
      y2_q     <= '0;
    end else if (act) begin
      case (cmd)
        CMD_RESET: begin
          status_q <= STATUS_RST;
          rd_q     <= '0;
          hres_q   <= HRES_RST;
          vres_q   <= VRES_RST;
        end
        CMD_BLANK: status_q[BLANK_BIT] <= wr_data_i[0];
        CMD_DMA:   status_q[DMA_LSB +: 2] <= wr_data_i[1:0];
        CMD_START: begin
          dx_q <= wr_data_i[9:0];
          dy_q <= wr_data_i[19:10];
        end
        CMD_HRANGE: begin
          x1_q <= wr_data_i[11:0];
          x2_q <= wr_data_i[23:12];
        end
        CMD_VRANGE: begin
          y1_q <= wr_data_i[9:0];
          y2_q <= wr_data_i[19:10];
        end
        CMD_MODE: begin
          status_q[22:16] <= {wr_data_i[5:0], wr_data_i[6]};
          hres_q          <= hres_of({wr_data_i[1:0], wr_data_i[6]});
          vres_q          <= vres_of(wr_data_i[3:2]);
        end
        default: if (cmd[7:4] == 4'h1) rd_q <= qval;
      endcase
    end
  end

  assign status_o  = {lcf_i, status_q[30:0]};
  assign rd_data_o = rd_q;
  assign busy_o    = busy;
  assign disp_x_o  = dx_q;
  assign disp_y_o  = dy_q;
  assign hres_o    = hres_q;
  assign vres_o    = vres_q;
  assign blank_o   = status_q[BLANK_BIT];
  assign dma_dir_o = status_q[DMA_LSB +: 2];
endmodule

// File: rtl/disp_ctrl_dec_chk.sv
module disp_ctrl_dec_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_valid_i,
  input logic [31:0] wr_data_i,
  input logic        wr_ready_o,
  input logic [31:0] status_o,
  input logic [31:0] rd_data_o,
  input logic        busy_o,
  input logic [9:0]  hres_o,
  input logic [9:0]  width_o,
  input logic [10:0] height_o,
  input logic        blank_o,
  input logic [1:0]  dma_dir_o
);
  logic acc;
  assign acc = wr_valid_i && wr_ready_o;

  p_reset_cmd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && wr_data_i[31:24] == 8'h00) |=>
      (status_o[30:0] == 31'h1480_2000 && width_o == 10'd256 && height_o == 11'd240
       && rd_data_o == 32'd0 && !busy_o));

  p_blank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && wr_data_i[31:24] == 8'h03) |=> (blank_o == $past(wr_data_i[0])));

  p_dma_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && wr_data_i[31:24] == 8'h04) |=> (dma_dir_o == $past(wr_data_i[1:0])));

  p_width_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (width_o <= hres_o));

  p_query_const_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && wr_data_i[31:24] == 8'h17) |=> (rd_data_o == 32'd2));

  p_query_nostall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && wr_data_i[31:28] == 4'h1) |=> wr_ready_o);

  p_stall_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ready_o |=> $stable(status_o[30:0]));
endmodule

bind disp_ctrl_dec disp_ctrl_dec_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_i (wr_valid_i),
  .wr_data_i  (wr_data_i),
  .wr_ready_o (wr_ready_o),
  .status_o   (status_o),
  .rd_data_o  (rd_data_o),
  .busy_o     (busy_o),
  .hres_o     (hres_o),
  .width_o    (width_o),
  .height_o   (height_o),
  .blank_o    (blank_o),
  .dma_dir_o  (dma_dir_o)
);

// File: tb/disp_ctrl_dec_tb.sv
module disp_ctrl_dec_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        wr_ready_o;
  logic        env_we_i = 1'b0;
  logic [2:0]  env_idx_i = '0;
  logic [31:0] env_data_i = '0;
  logic        lcf_i = 1'b0;
  logic [31:0] status_o, rd_data_o;
  logic        busy_o, blank_o;
  logic [9:0]  disp_x_o, disp_y_o, hres_o, width_o;
  logic [8:0]  vres_o;
  logic [10:0] height_o;
  logic [1:0]  dma_dir_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  disp_ctrl_dec u_dut (.*);

  // reference model
  logic [31:0] m_slot [16];
  logic [31:0] m_env [8];
  logic [31:0] m_status, m_rd;
  int m_hres, m_vres, m_w, m_h, m_x1, m_x2, m_y1, m_y2, m_sx, m_sy;

  function automatic int f_width(int x1, int x2, int hr);
    int sw = x2 - x1;
    if (sw <= 0 || sw >= 2560) return hr;
    return sw * hr / 2560;
  endfunction

  function automatic int f_height(int y1, int y2, bit dh, int vr);
    int sh = y2 - y1;
    if (dh) sh = sh * 2;
    if (sh <= 0) return vr;
    return sh;
  endfunction

  function automatic int f_hres(int i);
    int t [8] = '{256, 368, 320, 384, 512, 512, 640, 640};
    return t[i];
  endfunction

  function automatic int f_vres(int i);
    int t [4] = '{240, 480, 256, 480};
    return t[i];
  endfunction

  task automatic m_reset();
    for (int s = 0; s < 16; s++) m_slot[s] = (s == 3) ? 32'd1 : 32'd0;
    m_status = 32'h1480_2000;
    m_rd = 0; m_hres = 256; m_w = 256; m_vres = 240; m_h = 240;
  endtask

  task automatic m_apply(input logic [31:0] d, output bit busy);
    int cmd = int'(d[31:24]);
    busy = 0;
    if (cmd != 0 && cmd < 16 && m_slot[cmd] == d) return;
    if (cmd < 16) m_slot[cmd] = d;
    case (cmd)
      0: m_reset();
      3: m_status[23] = d[0];
      4: m_status[30:29] = d[1:0];
      5: begin m_sx = int'(d[9:0]); m_sy = int'(d[19:10]); end
      6: begin
        m_x1 = int'(d[11:0]); m_x2 = int'(d[23:12]);
        m_w = f_width(m_x1, m_x2, m_hres); busy = 1;
      end
      7: begin
        m_y1 = int'(d[9:0]); m_y2 = int'(d[19:10]);
        m_h = f_height(m_y1, m_y2, m_status[19], m_vres); busy = 1;
      end
      8: begin
        m_status = (m_status & ~32'h007f_0000) | ((d & 32'h3f) << 17) | ((d & 32'h40) << 10);
        m_hres = f_hres(int'(m_status[18:16]));
        m_vres = f_vres(int'(m_status[20:19]));
        m_w = f_width(m_x1, m_x2, m_hres);
        m_h = f_height(m_y1, m_y2, m_status[19], m_vres);
        busy = 1;
      end
      default: if (cmd >= 16 && cmd < 32) begin
        case (cmd & 15)
          2, 3, 4, 5: m_rd = m_env[cmd & 7] & 32'hfffff;
          6:          m_rd = m_env[5] & 32'hfffff;
          7:          m_rd = 2;
          default:    m_rd = 0;
        endcase
      end
    endcase
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, "/R7"}, "status", {1'b0, status_o[30:0]}, {1'b0, m_status[30:0]});
    chk({tag, "/R9"}, "lcf", 32'(status_o[31]), 32'(lcf_i));
    chk({tag, "/R8"}, "rd", rd_data_o, m_rd);
    chk({tag, "/R5"}, "width", 32'(width_o), 32'(m_w));
    chk({tag, "/R6"}, "height", 32'(height_o), 32'(m_h));
    chk({tag, "/R7"}, "hres", 32'(hres_o), 32'(m_hres));
    chk({tag, "/R7"}, "vres", 32'(vres_o), 32'(m_vres));
    chk({tag, "/R3"}, "blank", 32'(blank_o), 32'(m_status[23]));
    chk({tag, "/R3"}, "dma", 32'(dma_dir_o), 32'(m_status[30:29]));
    chk({tag, "/R4"}, "start", {12'd0, disp_y_o, disp_x_o}, 32'((m_sy << 10) | m_sx));
  endtask

  task automatic env_write(input logic [2:0] i, input logic [31:0] v);
    @(negedge clk_i);
    env_we_i = 1'b1; env_idx_i = i; env_data_i = v;
    @(negedge clk_i);
    env_we_i = 1'b0;
    m_env[i] = v;
  endtask

  task automatic do_write(input logic [31:0] d, input string tag);
    bit b;
    @(negedge clk_i);
    while (!wr_ready_o) @(negedge clk_i);
    wr_valid_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    m_apply(d, b);
    chk({tag, "/R10"}, "ready_after", 32'(wr_ready_o), 32'(!b));
    if (b) begin
      @(negedge clk_i);
      chk({tag, "/R10"}, "ready_mid", 32'(wr_ready_o), 32'd0);
      @(negedge clk_i);
      chk({tag, "/R10"}, "ready_end", 32'(wr_ready_o), 32'd1);
    end
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit b;
    logic [31:0] d;
    void'($urandom(32'd4242));
    for (int e = 0; e < 8; e++) m_env[e] = 0;
    m_reset();
    m_x1 = 0; m_x2 = 0; m_y1 = 0; m_y2 = 0; m_sx = 0; m_sy = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1");
    chk("R10", "ready_idle", 32'(wr_ready_o), 32'd1);

    // R5 boundaries
    do_write({8'h06, 12'd2560, 12'd0}, "R5_full");
    do_write({8'h06, 12'd2559, 12'd0}, "R5_edge");
    do_write({8'h06, 12'd100, 12'd900}, "R5_neg");
    do_write({8'h06, 12'd1700, 12'd200}, "R5_mid");
    // R7 mode, R6 double height
    do_write(32'h0800_007f, "R7_max");
    do_write({8'h07, 4'd0, 10'd10, 10'd10}, "R6_zero");
    do_write({8'h07, 4'd0, 10'd20, 10'd10}, "R6_dbl");
    do_write(32'h0800_0001, "R7_368");
    do_write({8'h07, 4'd0, 10'd5, 10'd300}, "R6_neg");
    // R2: duplicate is dropped, no busy period
    do_write({8'h06, 12'd1700, 12'd200}, "R2_dup");
    do_write(32'h0500_1234, "R4_start");
    // R2: reset never dropped
    do_write(32'h0000_0000, "R1_cmd0");
    do_write(32'h0300_0000, "R3_blank0");
    do_write(32'h0000_0000, "R2_cmd0_again");
    do_write(32'h0400_0002, "R3_dma");
    do_write(32'h0300_0001, "R2_slot3");

    // R10: word presented while busy is not taken
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_data_i = {8'h06, 12'd1000, 12'd3};
    @(negedge clk_i);
    m_apply({8'h06, 12'd1000, 12'd3}, b);
    wr_data_i = 32'h0300_0000;
    @(negedge clk_i);
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    chk("R10", "ready_back", 32'(wr_ready_o), 32'd1);
    check_all("R10_stall");

    // R8 queries
    for (int e = 0; e < 8; e++) env_write(3'(e), $urandom());
    for (int n = 0; n < 16; n++) do_write({8'h10 | 8'(n), 24'(n * 77)}, "R8_q");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int r = $urandom_range(0, 24);
      logic [7:0] c;
      if ($urandom_range(0, 5) == 0) env_write(3'($urandom()), $urandom());
      lcf_i = 1'($urandom());
      case (r)
        0:       c = 8'h00;
        1, 2:    c = 8'h03;
        3, 4:    c = 8'h04;
        5, 6:    c = 8'h05;
        7, 8, 9: c = 8'h06;
        10, 11:  c = 8'h07;
        12, 13:  c = 8'h08;
        14:      c = 8'h01;
        default: c = 8'h10 | 8'($urandom_range(0, 15));
      endcase
      d = {c, 24'($urandom())};
      if (c != 8'h00 && c < 8'h10 && $urandom_range(0, 3) == 0) d = m_slot[c];
      do_write(d, "RND");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule